// File: doc/BRIEF.md
# Buffered-Duty PWM Generator

This block produces a pulse-width-modulated signal from an 8-bit up-counter. The counter advances on a count clock that is the system clock divided by 1, 2, 4 or 8, and it runs from zero up to a programmable period value, then wraps. Each period starts with the output high. The output drops low once the counter reaches the active duty value.

Software writes the duty, the period, the divider selection and an output gate through separate write strobes. A new duty value is held in a staging register and moves into the active buffer only at the wrap, so the pulse in progress is never cut short or stretched. A restart command returns the counter and the divider to zero. A sticky flag marks every wrap and is cleared by writing 0 to it.

Top module: `pwm_gen`

## Requirements
- R1: After reset, `pwm_out` and `period_flag` are 0, and the counter, active buffer, duty and period are 0.
- R2: `cfg_div` selects the count clock as the system clock divided by 1, 2, 4 or 8 (encodings 0, 1, 2, 3). One period lasts (period + 1) count clocks, and `period_flag` is set once per period, at the wrap from the period value to 0.
- R3: Within a period the output is high for duty count clocks from the start of the period and low for the rest, so it is high for duty × divisor system clocks.
- R4: A buffered duty of 0 keeps the output low for the whole period. A buffered duty greater than the period keeps it high for the whole period.
- R5: A duty write during a period does not change the current pulse. The written value is copied into the active buffer at the next wrap.
- R6: While the output gate `cfg_out_en` (latched on `cfg_we`) is 0, `pwm_out` stays 0.
- R7: A `restart` pulse sets the counter and the divider phase to zero, so the next wrap comes (period + 1) × divisor cycles later. The active duty buffer is kept.
- R8: Writing 0 to the flag (`flag_we` with `flag_wdata` = 0) clears it, and writing 1 has no effect. If a clear and a wrap fall in the same cycle, the flag is set.
- R9: With a duty of 0x80, a period of 0xFF and a divisor of 1, the output is high for exactly 128 of 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duty_we | input | 1 | Duty register write strobe |
| duty_wdata | input | W | New duty value |
| period_we | input | 1 | Period register write strobe |
| period_wdata | input | W | New period value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 2 | Count clock divider select (0:/1, 1:/2, 2:/4, 3:/8) |
| cfg_out_en | input | 1 | Output gate |
| restart | input | 1 | Restart counter and divider |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write value (0 clears, 1 has no effect) |
| pwm_out | output | 1 | Gated PWM output |
| period_flag | output | 1 | Sticky wrap flag |

## Verification
Software clearing the flag and the hardware setting it at a wrap can fall in the same cycle. The bench provokes this in every measured period: it issues the clear write in the last cycle before the wrap. The flag must then read 1 on the following sample, because the set takes priority. A second overlap is a duty write landing mid-period. The bench judges it by counting the high cycles of that period against the old duty value.

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         duty_we,
  input  logic [W-1:0] duty_wdata,
  input  logic         period_we,
  input  logic [W-1:0] period_wdata,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_div,
  input  logic         cfg_out_en,
  input  logic         restart,
  input  logic         flag_we,
  input  logic         flag_wdata,
  output logic         pwm_out,
  output logic         period_flag
);
  logic [W-1:0] duty_q, period_q, act_q, cnt_q;
  logic [1:0]   div_q;
  logic         en_q, flag_q;
  logic [2:0]   pre_q, mask;
  logic         tick, wrap;

  assign mask = (3'd1 << div_q) - 3'd1;
  assign tick = (pre_q & mask) == mask;
  assign wrap = tick && (cnt_q == period_q) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q   <= '0;
      period_q <= '0;
      div_q    <= '0;
      en_q     <= 1'b0;
    end else begin
      if (duty_we)   duty_q   <= duty_wdata;
      if (period_we) period_q <= period_wdata;
      if (cfg_we) begin
        div_q <= cfg_div;
        en_q  <= cfg_out_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      pre_q <= restart ? 3'd0 : pre_q + 3'd1;
      if (restart || wrap) cnt_q <= '0;
      else if (tick)       cnt_q <= cnt_q + 1'b1;
      if (wrap) act_q <= duty_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag_q <= 1'b0;
    else if (wrap)                  flag_q <= 1'b1;
    else if (flag_we && !flag_wdata) flag_q <= 1'b0;
  end

  assign pwm_out     = en_q && (cnt_q < act_q);
  assign period_flag = flag_q;
endmodule

module pwm_gen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wrap,
  input logic         restart,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] act_q,
  input logic         flag_we,
  input logic         flag_wdata,
  input logic         pwm_out,
  input logic         period_flag
);
  // R8
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> period_flag);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_flag && !(flag_we && !flag_wdata) |=> period_flag);
  // R5
  buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));
  // R4
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == '0 |-> !pwm_out);
  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !restart |=> $stable(cnt_q));
endmodule

bind pwm_gen pwm_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .restart(restart),
  .cnt_q(cnt_q), .act_q(act_q), .flag_we(flag_we), .flag_wdata(flag_wdata),
  .pwm_out(pwm_out), .period_flag(period_flag));

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
module tb_pwm_gen;
  logic clk = 0, rst_n = 0;
  logic duty_we = 0, period_we = 0, cfg_we = 0, restart = 0, flag_we = 0, flag_wdata = 0;
  logic [7:0] duty_wdata = 0, period_wdata = 0;
  logic [1:0] cfg_div = 0;
  logic cfg_out_en = 0;
  logic pwm_out, period_flag;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_gen #(.W(8)) dut (.*);

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(int sel, int p, int d, bit en);
    int n, highs, flagbad, exp_h, nn;
    nn = (p + 1) * (1 << sel);
    @(negedge clk);
    cfg_we = 1; cfg_div = 2'(sel); cfg_out_en = en;
    period_we = 1; period_wdata = 8'(p);
    duty_we = 1; duty_wdata = 8'(d);
    restart = 1; flag_we = 1; flag_wdata = 0;
    @(negedge clk);
    cfg_we = 0; period_we = 0; duty_we = 0; restart = 0; flag_we = 0;
    n = 0;
    while (!period_flag && n < 5000) begin @(negedge clk); n++; end
    highs = 0; flagbad = 0;
    for (int i = 0; i <= nn; i++) begin
      if (i > 0) @(negedge clk);
      if (i < nn) begin
        highs += int'(pwm_out);
        if (i >= 1 && period_flag) flagbad++;
      end else begin
        // R8: clear write in the wrap cycle loses to the set
        check(period_flag == 1'b1, "R8 flag after wrap with concurrent clear", period_flag, 1);
      end
      flag_we    = (i == 0) || (i == 3) || (i == nn - 1);
      flag_wdata = (i == 3);
      duty_we    = (i == 2);
      duty_wdata = ~8'(d);
    end
    flag_we = 0; duty_we = 0;
    // R2 R8: flag stays clear (including after a write of 1) until the wrap
    check(flagbad == 0, "R2 R8 flag clear within period", flagbad, 0);
    exp_h = !en ? 0 : (d > p) ? nn : d * (1 << sel);
    // R3 R4 R5 R6 R9: high time against the duty loaded at the wrap
    check(highs == exp_h, $sformatf("R3 R4 R5 R6 R9 high count sel=%0d p=%0d d=%0d en=%0d", sel, p, d, en),
          highs, exp_h);
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(pwm_out == 0, "R1 reset output", pwm_out, 0);
    check(period_flag == 0, "R1 reset flag", period_flag, 0);
    rst_n = 1;
    @(negedge clk);
    cfg_we = 1; cfg_out_en = 1; @(negedge clk); cfg_we = 0;
    repeat (4) @(negedge clk);
    // R1: zero buffer keeps the output low even when gated on
    check(pwm_out == 0, "R1 output low after reset", pwm_out, 0);

    for (int s = 0; s < 4; s++)
      for (int pi = 0; pi < 2; pi++) begin
        int p;
        p = (pi == 0) ? 4 : 6;
        for (int d = 0; d <= p + 2; d++) measure(s, p, d, 1'b1);
      end
    // R6
    measure(0, 4, 2, 1'b0);
    measure(2, 6, 5, 1'b0);
    // R9
    measure(0, 255, 128, 1'b1);

    // R7: restart mid-period; buffer now holds ~2 (> period), flag timing restarts
    measure(1, 4, 2, 1'b1);
    repeat (3) @(negedge clk);
    restart = 1; flag_we = 1; flag_wdata = 0;
    begin
      int highs, bad;
      highs = 0; bad = 0;
      for (int j = 0; j <= 10; j++) begin
        @(negedge clk);
        restart = 0; flag_we = 0;
        if (j < 10) begin
          highs += int'(pwm_out);
          if (period_flag) bad++;
        end else check(period_flag == 1, "R7 wrap one period after restart", period_flag, 1);
      end
      check(bad == 0, "R7 no early wrap after restart", bad, 0);
      check(highs == 10, "R7 buffer kept across restart", highs, 10);
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  end
endmodule